// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block is the bus front end of a multicore processor's private peripheral window, an 8 KB region. A single register-bus request carries an address, a write enable, write data and the ID of the core that issued it. The block holds a small snoop-control register set in the first 256-byte page. It decodes the rest of the window into one-hot select strobes and a local offset for each attached unit: the interrupt CPU interfaces, the per-core timers, the per-core watchdogs and the shared interrupt distributor. The attached units return read data to the block, which registers it and hands it back one cycle after the request is accepted.

Each unit class that is replicated per core has one page for the requesting core's own view, followed by one page for each core in index order. Software can therefore reach its own bank at a fixed offset, or reach any core's bank explicitly. The block also gathers each core's timer and watchdog interrupt lines into a 32-line private interrupt block per core, at fixed positions.

Top module: `mpriv_decoder`

## Requirements
- R1: After reset, rsp_valid, rsp_err and every ppi bit are 0 and the control register reads 0. req_ready is 0 during reset and 1 from the first clock after reset.
- R2: The control register at byte offset 0x000 keeps only write-data bit 0. Bits DW-1..1 of a read of it are always 0.
- R3: The configuration word at 0x004 is read-only. Bits 3..0 hold NCORE-1 and bits 4..4+NCORE-1 are all ones; every other bit is 0. A write to it changes nothing.
- R4: Offsets 0x008 (core status) and 0x00C (invalidate-all) read 0. Writes to them leave the control register and every other bit of the block unchanged.
- R5: Any other address in 0x000-0x0FF, any page 0x100-0xFFF not listed in R6/R7, and bytes 0x40-0xFF inside a timer page are unmapped. Such an access reads 0, asserts no strobe and raises rsp_err together with its rsp_valid for exactly one cycle.
- R6: Page 0x100 selects the CPU interface of the requesting core, and page 0x100*(k+2) selects that of core k. unit_off is address bits 7:0.
- R7: Page 0x600+0x100*v is timer view v, where v=0 is the requesting core and v=k+1 is core k. Its bytes 0x00-0x1F select the timer and bytes 0x20-0x3F select the watchdog. unit_off is address bits 4:0.
- R8: Addresses 0x1000-0x1FFF select the distributor, and unit_off is address bits 11:0.
- R9: In the own-core views (0x100, 0x600, 0x620), the same address reaches the bank of whichever core req_core names.
- R10: An accepted request yields rsp_valid exactly one cycle later. rsp_rdata then holds the addressed read data for a read and 0 for a write. Cycles with no accepted request yield rsp_valid = 0.
- R11: ppi[32*c+29] follows tmr_irq[c] and ppi[32*c+30] follows wdg_irq[c], each one clock later. All other ppi bits stay 0.
- R12: At most one select strobe is high at a time, and only in a cycle where a request is accepted. unit_we and unit_wdata pass through req_we and req_wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 13 | Byte offset within the window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| req_core | input | CORE_W | Issuing core ID |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DW | Registered read data |
| rsp_err | output | 1 | Unmapped-access pulse |
| unit_we | output | 1 | Write enable to the units |
| unit_wdata | output | DW | Write data to the units |
| unit_off | output | 12 | Local offset within the selected unit |
| sel_cpuif | output | NCORE | Per-core CPU interface select |
| sel_tmr | output | NCORE | Per-core timer select |
| sel_wdg | output | NCORE | Per-core watchdog select |
| sel_dist | output | 1 | Distributor select |
| cpuif_rdata | input | NCORE*DW | CPU interface read data, core c at bits DW*c |
| tmr_rdata | input | NCORE*DW | Timer read data |
| wdg_rdata | input | NCORE*DW | Watchdog read data |
| dist_rdata | input | DW | Distributor read data |
| tmr_irq | input | NCORE | Per-core timer interrupt |
| wdg_irq | input | NCORE | Per-core watchdog interrupt |
| ppi | output | NCORE*32 | Private interrupt lines, 32 per core |

## Verification
A wrong view-to-core resolution shows up as a strobe on the wrong core's bit in the same cycle the request is driven. It also shows up one cycle later as read data taken from the wrong stub bank. A corrupted control bit or configuration word appears on rsp_rdata in the cycle after the read that targets it. A mis-wired interrupt position shows on ppi one clock after the source line changes. The reference model checks strobes in the request cycle and the response in the next cycle, so every fault is caught within one cycle of the access that exposes it.

// File: rtl/mpriv_pkg.sv
`timescale 1ns/1ps
package mpriv_pkg;
  typedef enum logic [2:0] {
    U_NONE  = 3'd0,
    U_SCU   = 3'd1,
    U_CPUIF = 3'd2,
    U_TMR   = 3'd3,
    U_WDG   = 3'd4,
    U_DIST  = 3'd5
  } unit_e;

  localparam int WIN_AW      = 13;
  localparam int OFF_W       = 12;
  localparam int CPUIF_PAGE0 = 1;
  localparam int TMR_PAGE0   = 6;
  localparam int PPI_LINES   = 32;
  localparam int PPI_TMR_POS = 29;
  localparam int PPI_WDG_POS = 30;
endpackage

// File: rtl/mpriv_addr_dec.sv
`timescale 1ns/1ps
module mpriv_addr_dec
  import mpriv_pkg::*;
#(
  parameter int NCORE  = 1,
  parameter int CORE_W = 1
) (
  input  logic [WIN_AW-1:0] addr,
  input  logic [CORE_W-1:0] req_core,
  output unit_e             unit,
  output logic [CORE_W-1:0] core,
  output logic [OFF_W-1:0]  off
);
  int pg;
  int view;

  always_comb begin
    unit = U_NONE;
    core = '0;
    off  = '0;
    view = 0;
    pg   = int'(addr[11:8]);
    if (addr[12]) begin
      unit = U_DIST;
      off  = addr[11:0];
    end else if (pg == 0) begin
      unit = U_SCU;
      off  = {4'b0, addr[7:0]};
    end else if (pg >= CPUIF_PAGE0 && pg <= CPUIF_PAGE0 + NCORE) begin
      unit = U_CPUIF;
      view = pg - CPUIF_PAGE0;
      off  = {4'b0, addr[7:0]};
    end else if (pg >= TMR_PAGE0 && pg <= TMR_PAGE0 + NCORE && addr[7:6] == 2'b00) begin
      unit = addr[5] ? U_WDG : U_TMR;
      view = pg - TMR_PAGE0;
      off  = {7'b0, addr[4:0]};
    end
    if (unit == U_CPUIF || unit == U_TMR || unit == U_WDG) begin
      if (view == 0) begin
        if (int'(req_core) < NCORE) core = req_core;
        else begin
          unit = U_NONE;
          off  = '0;
        end
      end else begin
        core = CORE_W'(view - 1);
      end
    end
  end
endmodule

// File: rtl/mpriv_scu_regs.sv
`timescale 1ns/1ps
module mpriv_scu_regs #(
  parameter int NCORE = 1,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          we,
  input  logic [7:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bad
);
  localparam logic [DW-1:0] CFG_WORD =
    (DW'((1 << NCORE) - 1) << 4) | DW'(NCORE - 1);

  logic ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 1'b0;
    else if (hit && we && off == 8'h00) ctrl_q <= wdata[0];
  end

  always_comb begin
    rdata = '0;
    bad   = 1'b0;
    case (off)
      8'h00:        rdata = {{(DW-1){1'b0}}, ctrl_q};
      8'h04:        rdata = CFG_WORD;
      8'h08, 8'h0C: rdata = '0;
      default:      bad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/mpriv_irq_route.sv
`timescale 1ns/1ps
module mpriv_irq_route
  import mpriv_pkg::*;
#(
  parameter int NCORE = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCORE-1:0]           tmr_irq,
  input  logic [NCORE-1:0]           wdg_irq,
  output logic [NCORE*PPI_LINES-1:0] ppi
);
  logic [NCORE*PPI_LINES-1:0] ppi_d;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    always_comb begin
      ppi_d[g*PPI_LINES +: PPI_LINES]              = '0;
      ppi_d[g*PPI_LINES + PPI_TMR_POS]             = tmr_irq[g];
      ppi_d[g*PPI_LINES + PPI_WDG_POS]             = wdg_irq[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ppi <= '0;
    else     ppi <= ppi_d;
  end
endmodule

// File: rtl/mpriv_decoder.sv
`timescale 1ns/1ps
module mpriv_decoder
  import mpriv_pkg::*;
#(
  parameter int NCORE  = 1,
  parameter int DW     = 32,
  parameter int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [WIN_AW-1:0]          req_addr,
  input  logic                       req_we,
  input  logic [DW-1:0]              req_wdata,
  input  logic [CORE_W-1:0]          req_core,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_rdata,
  output logic                       rsp_err,
  output logic                       unit_we,
  output logic [DW-1:0]              unit_wdata,
  output logic [OFF_W-1:0]           unit_off,
  output logic [NCORE-1:0]           sel_cpuif,
  output logic [NCORE-1:0]           sel_tmr,
  output logic [NCORE-1:0]           sel_wdg,
  output logic                       sel_dist,
  input  logic [NCORE*DW-1:0]        cpuif_rdata,
  input  logic [NCORE*DW-1:0]        tmr_rdata,
  input  logic [NCORE*DW-1:0]        wdg_rdata,
  input  logic [DW-1:0]              dist_rdata,
  input  logic [NCORE-1:0]           tmr_irq,
  input  logic [NCORE-1:0]           wdg_irq,
  output logic [NCORE*PPI_LINES-1:0] ppi
);
  unit_e             unit;
  logic [CORE_W-1:0] core;
  logic              acc;
  logic              ready_q;
  logic [DW-1:0]     scu_rdata;
  logic              scu_bad;
  logic [DW-1:0]     rd_nxt;
  logic              err_nxt;
  logic [DW-1:0]     cpu_rd [NCORE];
  logic [DW-1:0]     tmr_rd [NCORE];
  logic [DW-1:0]     wdg_rd [NCORE];

  assign acc        = req_valid && ready_q;
  assign req_ready  = ready_q;
  assign unit_we    = req_we;
  assign unit_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  mpriv_addr_dec #(.NCORE(NCORE), .CORE_W(CORE_W)) u_dec (
    .addr     (req_addr),
    .req_core (req_core),
    .unit     (unit),
    .core     (core),
    .off      (unit_off)
  );

  mpriv_scu_regs #(.NCORE(NCORE), .DW(DW)) u_scu (
    .clk   (clk),
    .rst   (rst),
    .hit   (acc && unit == U_SCU),
    .we    (req_we),
    .off   (req_addr[7:0]),
    .wdata (req_wdata),
    .rdata (scu_rdata),
    .bad   (scu_bad)
  );

  mpriv_irq_route #(.NCORE(NCORE)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .tmr_irq (tmr_irq),
    .wdg_irq (wdg_irq),
    .ppi     (ppi)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    logic hit_core;
    assign hit_core     = acc && core == CORE_W'(g);
    assign sel_cpuif[g] = hit_core && unit == U_CPUIF;
    assign sel_tmr[g]   = hit_core && unit == U_TMR;
    assign sel_wdg[g]   = hit_core && unit == U_WDG;
    assign cpu_rd[g]    = cpuif_rdata[g*DW +: DW];
    assign tmr_rd[g]    = tmr_rdata[g*DW +: DW];
    assign wdg_rd[g]    = wdg_rdata[g*DW +: DW];
  end
  assign sel_dist = acc && unit == U_DIST;

  always_comb begin
    rd_nxt = '0;
    case (unit)
      U_SCU:  rd_nxt = scu_rdata;
      U_DIST: rd_nxt = dist_rdata;
      U_CPUIF, U_TMR, U_WDG: begin
        for (int c = 0; c < NCORE; c++) begin
          if (core == CORE_W'(c)) begin
            if (unit == U_CPUIF)    rd_nxt = cpu_rd[c];
            else if (unit == U_TMR) rd_nxt = tmr_rd[c];
            else                    rd_nxt = wdg_rd[c];
          end
        end
      end
      default: rd_nxt = '0;
    endcase
  end

  assign err_nxt = acc && (unit == U_NONE || (unit == U_SCU && scu_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= (acc && !req_we) ? rd_nxt : '0;
      rsp_err   <= err_nxt;
    end
  end
endmodule

// File: rtl/mpriv_decoder_chk.sv
`timescale 1ns/1ps
module mpriv_decoder_chk
  import mpriv_pkg::*;
#(
  parameter int NCORE  = 1,
  parameter int DW     = 32,
  parameter int CORE_W = 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic [WIN_AW-1:0]          req_addr,
  input logic                       req_we,
  input logic                       rsp_valid,
  input logic [DW-1:0]              rsp_rdata,
  input logic                       rsp_err,
  input logic [NCORE-1:0]           sel_cpuif,
  input logic [NCORE-1:0]           sel_tmr,
  input logic [NCORE-1:0]           sel_wdg,
  input logic                       sel_dist,
  input logic [NCORE-1:0]           tmr_irq,
  input logic [NCORE-1:0]           wdg_irq,
  input logic [NCORE*PPI_LINES-1:0] ppi
);
  localparam logic [DW-1:0] CFG_WORD =
    (DW'((1 << NCORE) - 1) << 4) | DW'(NCORE - 1);

  logic warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  initial begin
    AST_CORE_RANGE: assert (NCORE >= 1 && NCORE <= 4); // R6
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_cpuif, sel_tmr, sel_wdg, sel_dist})); // R12
  AST_SELECT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (|{sel_cpuif, sel_tmr, sel_wdg, sel_dist}) |-> (req_valid && req_ready)); // R12
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid); // R10
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R5
  AST_CFG_CONSTANT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_we && req_addr == 13'h004) |=> rsp_rdata == CFG_WORD); // R3
  AST_CTRL_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_we && req_addr == 13'h000) |=> rsp_rdata[DW-1:1] == '0); // R2

  for (genvar g = 0; g < NCORE; g++) begin : g_ppi
    AST_PPI_TIMER: assert property (@(posedge clk) disable iff (rst || !warm)
      ppi[g*PPI_LINES + PPI_TMR_POS] == $past(tmr_irq[g])); // R11
    AST_PPI_WATCHDOG: assert property (@(posedge clk) disable iff (rst || !warm)
      ppi[g*PPI_LINES + PPI_WDG_POS] == $past(wdg_irq[g])); // R11
  end
endmodule

bind mpriv_decoder mpriv_decoder_chk #(.NCORE(NCORE), .DW(DW), .CORE_W(CORE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_we(req_we), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sel_cpuif(sel_cpuif),
  .sel_tmr(sel_tmr), .sel_wdg(sel_wdg), .sel_dist(sel_dist),
  .tmr_irq(tmr_irq), .wdg_irq(wdg_irq), .ppi(ppi)
);

// File: tb/mpriv_decoder_tb.sv
`timescale 1ns/1ps
module mpriv_decoder_tb;
  localparam int NC = 2;
  localparam int CW = 1;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [12:0] req_addr = '0;
  logic req_we = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] req_core = '0;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic unit_we;
  logic [DW-1:0] unit_wdata;
  logic [11:0] unit_off;
  logic [NC-1:0] sel_cpuif, sel_tmr, sel_wdg;
  logic sel_dist;
  logic [NC*DW-1:0] cpuif_rdata, tmr_rdata, wdg_rdata;
  logic [DW-1:0] dist_rdata;
  logic [NC-1:0] tmr_irq = '0, wdg_irq = '0;
  logic [NC*32-1:0] ppi;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mpriv_decoder #(.NCORE(NC), .DW(DW)) u_dut (.*);

  // Unit stubs: plain word stores addressed by unit_off.
  logic [DW-1:0] st_cpu [NC][64];
  logic [DW-1:0] st_tmr [NC][8];
  logic [DW-1:0] st_wdg [NC][8];
  logic [DW-1:0] st_dist [1024];

  initial begin
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < 64; i++) st_cpu[c][i] = '0;
      for (int i = 0; i < 8; i++) begin st_tmr[c][i] = '0; st_wdg[c][i] = '0; end
    end
    for (int i = 0; i < 1024; i++) st_dist[i] = '0;
  end

  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (sel_cpuif[c] && unit_we) st_cpu[c][unit_off[7:2]] <= unit_wdata;
      if (sel_tmr[c] && unit_we)   st_tmr[c][unit_off[4:2]] <= unit_wdata;
      if (sel_wdg[c] && unit_we)   st_wdg[c][unit_off[4:2]] <= unit_wdata;
    end
    if (sel_dist && unit_we) st_dist[unit_off[11:2]] <= unit_wdata;
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      cpuif_rdata[c*DW +: DW] = st_cpu[c][unit_off[7:2]];
      tmr_rdata[c*DW +: DW]   = st_tmr[c][unit_off[4:2]];
      wdg_rdata[c*DW +: DW]   = st_wdg[c][unit_off[4:2]];
    end
    dist_rdata = st_dist[unit_off[11:2]];
  end

  // Reference model state
  logic [DW-1:0] ref_mem [int];
  logic ref_ctrl = 1'b0;
  logic exp_valid = 1'b0;
  logic [DW-1:0] exp_rdata = '0;
  logic exp_err = 1'b0;
  string exp_tag = "R10";

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // unit: 0 none,1 scu,2 cpuif,3 timer,4 watchdog,5 dist
  task automatic ref_decode(input int a, input int cid, output int u, output int c, output int off);
    int page, inpg;
    u = 0; c = 0; off = 0;
    page = a / 256;
    inpg = a % 256;
    if (a >= 4096) begin u = 5; off = a - 4096; end
    else if (a < 256) begin u = 1; off = inpg; end
    else if (page >= 1 && page <= NC + 1) begin
      u = 2; off = inpg; c = (page == 1) ? cid : page - 2;
    end else if (page >= 6 && page <= 6 + NC && inpg < 64) begin
      u = (inpg >= 32) ? 4 : 3; off = inpg % 32; c = (page == 6) ? cid : page - 7;
    end
  endtask

  task automatic check_rsp();
    chk(rsp_valid == exp_valid, "R10 rsp_valid", 64'(rsp_valid), 64'(exp_valid));
    if (exp_valid) begin
      chk(rsp_rdata == exp_rdata, {exp_tag, " rdata"}, 64'(rsp_rdata), 64'(exp_rdata));
      chk(rsp_err == exp_err, "R5 rsp_err", 64'(rsp_err), 64'(exp_err));
    end
  endtask

  task automatic idle();
    @(negedge clk);
    check_rsp();
    req_valid = 1'b0;
    exp_valid = 1'b0;
  endtask

  task automatic access(input int a, input bit we, input logic [DW-1:0] wd, input int cid, input string tag);
    int u, c, off, key;
    logic [NC-1:0] ec, et, ew;
    logic ed;
    logic [DW-1:0] rv;
    logic er;
    @(negedge clk);
    check_rsp();
    req_valid = 1'b1; req_addr = 13'(a); req_we = we; req_wdata = wd; req_core = CW'(cid);
    ref_decode(a, cid, u, c, off);
    ec = '0; et = '0; ew = '0; ed = 1'b0; rv = '0; er = 1'b0;
    key = (u << 16) | (c << 12) | (off >> 2);
    case (u)
      0: er = 1'b1;
      1: begin
        case (off)
          0: begin rv = {31'b0, ref_ctrl}; if (we) ref_ctrl = wd[0]; end
          4: rv = 32'((((1 << NC) - 1) << 4) | (NC - 1));
          8, 12: rv = '0;
          default: er = 1'b1;
        endcase
      end
      default: begin
        if (u == 2) ec[c] = 1'b1;
        if (u == 3) et[c] = 1'b1;
        if (u == 4) ew[c] = 1'b1;
        if (u == 5) ed = 1'b1;
        rv = ref_mem.exists(key) ? ref_mem[key] : '0;
        if (we) ref_mem[key] = wd;
      end
    endcase
    #1;
    chk({sel_cpuif, sel_tmr, sel_wdg, sel_dist} == {ec, et, ew, ed}, {tag, " R12 strobes"},
        64'({sel_cpuif, sel_tmr, sel_wdg, sel_dist}), 64'({ec, et, ew, ed}));
    if (u >= 2) chk(unit_off == 12'(off), {tag, " unit_off"}, 64'(unit_off), 64'(off));
    if (we) chk(unit_wdata == wd && unit_we, "R12 passthrough", 64'(unit_wdata), 64'(wd));
    exp_valid = 1'b1;
    exp_rdata = we ? '0 : rv;
    exp_err = er;
    exp_tag = tag;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 rsp during reset", 64'({rsp_valid, rsp_err}), 64'(0));
    chk(ppi == '0, "R1 ppi reset", 64'(ppi), 64'(0));
    chk(req_ready == 1'b0, "R1 ready in reset", 64'(req_ready), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'(1));
    access(13'h000, 1'b0, '0, 0, "R1");
    // R2 control register
    access(13'h000, 1'b1, 32'hFFFF_FFFE, 0, "R2");
    access(13'h000, 1'b0, '0, 0, "R2");
    access(13'h000, 1'b1, 32'hA5A5_A5A5, 1, "R2");
    access(13'h000, 1'b0, '0, 1, "R2");
    // R3 configuration
    access(13'h004, 1'b0, '0, 0, "R3");
    access(13'h004, 1'b1, 32'h0, 0, "R3");
    access(13'h004, 1'b0, '0, 1, "R3");
    // R4 status / invalidate
    access(13'h008, 1'b1, 32'hFFFF_FFFF, 0, "R4");
    access(13'h00C, 1'b1, 32'hFFFF_FFFE, 0, "R4");
    access(13'h008, 1'b0, '0, 0, "R4");
    access(13'h00C, 1'b0, '0, 0, "R4");
    access(13'h000, 1'b0, '0, 0, "R4 ctrl kept");
    // R5 unmapped
    access(13'h010, 1'b0, '0, 0, "R5");
    access(13'h0FC, 1'b1, 32'h1234, 0, "R5");
    access(13'h001, 1'b0, '0, 0, "R5");
    access(13'h440, 1'b1, 32'h55, 0, "R5");
    access(13'h640, 1'b0, '0, 0, "R5");
    access(13'h7FC, 1'b1, 32'h77, 1, "R5");
    access(13'h900, 1'b0, '0, 0, "R5");
    idle();
    // R6 / R9 CPU interfaces
    access(13'h104, 1'b1, 32'hC0DE_0000, 0, "R9");
    access(13'h104, 1'b1, 32'hC0DE_0001, 1, "R9");
    access(13'h204, 1'b0, '0, 1, "R6");
    access(13'h304, 1'b0, '0, 0, "R6");
    access(13'h3FC, 1'b1, 32'hBEEF, 0, "R6");
    access(13'h1FC, 1'b0, '0, 1, "R9");
    // R7 / R9 timers and watchdogs
    access(13'h608, 1'b1, 32'h7100, 1, "R9");
    access(13'h628, 1'b1, 32'h7200, 0, "R9");
    access(13'h808, 1'b0, '0, 0, "R7");
    access(13'h728, 1'b0, '0, 0, "R7");
    access(13'h73C, 1'b1, 32'h99, 0, "R7");
    access(13'h63C, 1'b0, '0, 0, "R9");
    access(13'h61C, 1'b0, '0, 1, "R7");
    // R8 distributor
    access(13'h1000, 1'b1, 32'hD15, 0, "R8");
    access(13'h1FFC, 1'b1, 32'hD16, 1, "R8");
    access(13'h1000, 1'b0, '0, 1, "R8");
    access(13'h1FFC, 1'b0, '0, 0, "R8");
    idle();
    idle();
    // R11 interrupt routing
    @(negedge clk);
    check_rsp();
    tmr_irq = 2'b01; wdg_irq = 2'b10;
    @(negedge clk);
    check_rsp();
    chk(ppi == ((64'd1 << 29) | (64'd1 << 62)), "R11 ppi pattern A", 64'(ppi), (64'd1 << 29) | (64'd1 << 62));
    tmr_irq = 2'b10; wdg_irq = 2'b01;
    @(negedge clk);
    check_rsp();
    chk(ppi == ((64'd1 << 61) | (64'd1 << 30)), "R11 ppi pattern B", 64'(ppi), (64'd1 << 61) | (64'd1 << 30));
    tmr_irq = 2'b00; wdg_irq = 2'b00;
    @(negedge clk);
    chk(ppi == '0, "R11 ppi clear", 64'(ppi), 64'(0));
    // Mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int sel, a;
      sel = int'($urandom % 5);
      case (sel)
        0: a = int'($urandom % 64) * 4;
        1: a = 256 + int'($urandom % 768);
        2: a = 1536 + int'($urandom % 768);
        3: a = 4096 + int'($urandom % 4096);
        default: a = int'($urandom % 8192);
      endcase
      a = a & ~3;
      access(a, 1'($urandom), $urandom, int'($urandom % NC), "R10 mix");
      if ((n % 7) == 3) idle();
    end
    idle();
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule